// File: doc/BRIEF.md
# Header-Driven Register Loader

This block fills a bank of channel configuration registers from a stream of 32-bit command words. Every command opens with a header word, a bitmask. Each defined bit that is set in the header announces that one payload word for the matching register follows. The payload words are packed: registers whose bit is clear take no stream slot. The loader walks the set bits from the lowest to the highest and writes each arriving word to the register named by the current bit. When the last announced word has landed, it raises a one-cycle completion pulse.

The input is a valid/ready stream. A word moves on any cycle where both valid and ready are high. Ready is low while reset is applied and high in every cycle after that, so the loader never applies back-pressure. The producer may drop valid for any number of cycles between words, and those idle cycles have no effect. While valid is low, the data lines are don't-care. Header bit 0 is a clear request: all registers are zeroed before any payload of that command is written. The register contents are presented in parallel on one wide output, so the channel logic can read them directly.

Top module: `cfg_word_loader`

## Requirements
- R1: When an accepted header has bit 0 set, every register slot reads zero in the cycle after the header. Payload words of that command then load on top of the zeroed bank.
- R2: Payload words are consumed one per selected header bit, from the lowest selected bit to the highest, with no gaps. Each word lands in the slot of the bit it was consumed for.
- R3: Header bit k selects slot k, and slot k is bits [32k+31:32k] of `reg_file_o`. The defined select bits are 2 through 12, 14, 19, 20, 29, 30 and 31. For example, bit 3 is the control word, bits 4 and 5 are the source address, bit 14 is the fill value, and bits 30 and 31 are the next-link address.
- R4: Header bits 1, 13, 15 to 18 and 21 to 28 have no register. They consume no payload word, and their slots always read zero.
- R5: A header with no defined select bit set completes on the header alone: `load_done` is high in the cycle after the header is accepted.
- R6: `load_done` is high for exactly the one cycle after the final payload word is accepted. It is low while earlier words of the command are being accepted. The next accepted word is then treated as a header.
- R7: `in_ready` is high in every cycle after reset. A word transfers only when `in_valid` is high. Cycles with `in_valid` low change nothing.
- R8: During reset, `in_ready` and `load_done` are low. After reset, all slots read zero and the loader expects a header.
- R9: Slots that a command does not select keep their earlier values, unless that command requests a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Command word valid |
| in_ready | output | 1 | Loader accepts a word |
| in_data | input | 32 | Command word (header or payload) |
| reg_file_o | output | 1024 | Register slots, slot k at bits [32k+31:32k] |
| load_done | output | 1 | One-cycle pulse when a command has fully loaded |

## Verification
The hardest situation to reach from the ports is a header whose set bits are all undefined, or a header that carries only the clear request. Such a command must finish on the header alone. If the loader wrongly waits for payload, it swallows the next header as data, and the damage shows up only in the command that follows. The stimulus drives such headers directly, and it also thins random headers with repeated AND-ing so that near-empty and undefined-only masks occur often. Every command is followed immediately by another one, so a swallowed word corrupts the next comparison. Random idle gaps with garbage on the data lines are mixed in to exercise the valid-low cycles.

// File: rtl/cwl_pkg.sv
package cwl_pkg;
  // width of one command word; one header bit per register slot
  localparam int unsigned WORD_W_DEF = 32;
  // header bits that name a real register
  localparam logic [31:0] SEL_MASK_DEF = 32'hE018_5FFC;
  // header bit that requests zeroing of the bank
  localparam int unsigned CLR_BIT_DEF = 0;

  typedef enum logic {
    ST_HDR = 1'b0,
    ST_PAY = 1'b1
  } ld_state_e;
endpackage

// File: rtl/cwl_lowest_pick.sv
module cwl_lowest_pick #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o
);
  // seen[i] is set when any request below bit i is present
  logic [N:0] seen;
  assign seen[0] = 1'b0;

  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_chain
      assign seen[gi+1]  = seen[gi] | req_i[gi];
      assign grant_o[gi] = req_i[gi] & ~seen[gi];
    end
  endgenerate

  // R2: at most one grant, and never above a pending lower request
  a_r2_single_grant: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant_o));
  a_r2_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o != '0) |-> (((grant_o - 1'b1) & req_i) == '0));
  a_r2_grant_in_req: assert property (@(posedge clk) disable iff (!rst_n)
    ((grant_o & ~req_i) == '0));
endmodule

// File: rtl/cwl_sequencer.sv
module cwl_sequencer
  import cwl_pkg::*;
#(
  parameter int unsigned        WORD_W   = WORD_W_DEF,
  parameter logic [WORD_W-1:0]  SEL_MASK = WORD_W'(SEL_MASK_DEF),
  parameter int unsigned        CLR_BIT  = CLR_BIT_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic [WORD_W-1:0] pend_o,
  input  logic [WORD_W-1:0] grant_i,
  output logic [WORD_W-1:0] wr_sel_o,
  output logic [WORD_W-1:0] wr_data_o,
  output logic              clr_o,
  output logic              done_o
);
  ld_state_e         st_q;
  logic [WORD_W-1:0] pend_q;
  logic              rdy_q;
  logic              done_q;
  logic              fire;
  logic [WORD_W-1:0] hdr_sel;
  logic [WORD_W-1:0] rest;

  assign fire    = in_valid & rdy_q;
  assign hdr_sel = in_data & SEL_MASK;
  assign rest    = pend_q & ~grant_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_HDR;
      pend_q <= '0;
      rdy_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      rdy_q  <= 1'b1;
      done_q <= 1'b0;
      if (fire) begin
        case (st_q)
          ST_HDR: begin
            pend_q <= hdr_sel;
            if (hdr_sel == '0) begin
              done_q <= 1'b1;
            end else begin
              st_q <= ST_PAY;
            end
          end
          ST_PAY: begin
            pend_q <= rest;
            if (rest == '0) begin
              done_q <= 1'b1;
              st_q   <= ST_HDR;
            end
          end
          default: st_q <= ST_HDR;
        endcase
      end
    end
  end

  assign in_ready  = rdy_q;
  assign pend_o    = pend_q;
  assign wr_sel_o  = (st_q == ST_PAY && fire) ? grant_i : '0;
  assign wr_data_o = in_data;
  assign clr_o     = (st_q == ST_HDR) && fire && in_data[CLR_BIT];
  assign done_o    = done_q;

  // R2: each accepted payload word retires exactly one selected bit
  a_r2_one_bit_per_word: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_PAY && fire) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
  // R6: completion only follows an accepted word and leaves the header wait
  a_r6_done_after_word: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $past(fire));
  a_r6_done_in_header: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> (st_q == ST_HDR));
  // R5: nothing is pending while a header is awaited
  a_r5_idle_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_HDR) |-> (pend_q == '0));
  // R7: a cycle without valid leaves the progress untouched
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_valid && !done_q) |=> ($stable(pend_q) && !done_q));
endmodule

// File: rtl/cwl_reg_bank.sv
module cwl_reg_bank
  import cwl_pkg::*;
#(
  parameter int unsigned        WORD_W   = WORD_W_DEF,
  parameter logic [WORD_W-1:0]  SEL_MASK = WORD_W'(SEL_MASK_DEF)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clr_i,
  input  logic [WORD_W-1:0]        wr_sel_i,
  input  logic [WORD_W-1:0]        wr_data_i,
  output logic [WORD_W*WORD_W-1:0] regs_o
);
  localparam int unsigned NSLOT = WORD_W;

  genvar gk;
  generate
    for (gk = 0; gk < NSLOT; gk++) begin : g_slot
      if (SEL_MASK[gk]) begin : g_real
        logic [WORD_W-1:0] q;
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            q <= '0;
          end else if (clr_i) begin
            q <= '0;
          end else if (wr_sel_i[gk]) begin
            q <= wr_data_i;
          end
        end
        assign regs_o[gk*WORD_W +: WORD_W] = q;
      end else begin : g_none
        assign regs_o[gk*WORD_W +: WORD_W] = '0;
      end
    end
  endgenerate

  // R1: a clear request empties the bank by the next cycle
  a_r1_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (regs_o == '0));
  // R4: writes never target a slot without a register
  a_r4_no_undef_write: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_sel_i & ~SEL_MASK) == '0));
  // R2: one target per word
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel_i));
  // R9: slots not written and not cleared hold their value
  a_r9_hold_unselected: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && wr_sel_i == '0) |=> $stable(regs_o));
endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
  import cwl_pkg::*;
#(
  parameter int unsigned        WORD_W   = WORD_W_DEF,
  parameter logic [WORD_W-1:0]  SEL_MASK = WORD_W'(SEL_MASK_DEF),
  parameter int unsigned        CLR_BIT  = CLR_BIT_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic [WORD_W-1:0]        in_data,
  output logic [WORD_W*WORD_W-1:0] reg_file_o,
  output logic                     load_done
);
  logic [WORD_W-1:0] pend;
  logic [WORD_W-1:0] grant;
  logic [WORD_W-1:0] wr_sel;
  logic [WORD_W-1:0] wr_data;
  logic              clr;

  cwl_sequencer #(
    .WORD_W   (WORD_W),
    .SEL_MASK (SEL_MASK),
    .CLR_BIT  (CLR_BIT)
  ) i_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .pend_o    (pend),
    .grant_i   (grant),
    .wr_sel_o  (wr_sel),
    .wr_data_o (wr_data),
    .clr_o     (clr),
    .done_o    (load_done)
  );

  cwl_lowest_pick #(
    .N (WORD_W)
  ) i_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (pend),
    .grant_o (grant)
  );

  cwl_reg_bank #(
    .WORD_W   (WORD_W),
    .SEL_MASK (SEL_MASK)
  ) i_bank (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_i     (clr),
    .wr_sel_i  (wr_sel),
    .wr_data_i (wr_data),
    .regs_o    (reg_file_o)
  );

  // R8: ready stays low while reset is applied
  a_r8_ready_in_reset: assert property (@(posedge clk)
    !rst_n |-> !in_ready);
endmodule

// File: tb/test_cfg_word_loader.sv
module test_cfg_word_loader;
  localparam logic [31:0] DEF = 32'hE018_5FFC;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [31:0]   in_data;
  logic [1023:0] reg_file_o;
  logic          load_done;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_r [32];

  always #2 clk = ~clk;

  cfg_word_loader i_cfg_word_loader (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_data    (in_data),
    .reg_file_o (reg_file_o),
    .load_done  (load_done)
  );

  function automatic logic [31:0] slot(int k);
    return reg_file_o[k*32 +: 32];
  endfunction

  task automatic chk(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", rq, act, expv);
    end
  endtask

  task automatic cmp_all(string rq);
    int first = 0;
    bit ok = 1'b1;
    for (int k = 31; k >= 0; k--) begin
      if (slot(k) !== exp_r[k]) begin
        ok = 1'b0;
        first = k;
      end
    end
    chk(ok, rq, slot(first), exp_r[first]);
  endtask

  // drive one word; returns at the negedge after it was accepted
  task automatic send(logic [31:0] w, bit gaps);
    if (gaps) begin
      repeat ($urandom_range(0, 2)) @(negedge clk);
    end
    in_valid = 1'b1;
    in_data  = w;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    in_data  = $urandom;
  endtask

  task automatic run_cmd(logic [31:0] hdr, bit gaps);
    logic [31:0] sel;
    logic [31:0] w;
    sel = hdr & DEF;
    if (hdr[0]) begin
      for (int k = 0; k < 32; k++) exp_r[k] = '0;
    end
    send(hdr, gaps);
    if (sel == '0) begin
      chk(load_done === 1'b1, "R5 done on header alone", {31'd0, load_done}, 32'd1);
    end else begin
      for (int b = 0; b < 32; b++) begin
        if (sel[b]) begin
          w = $urandom;
          exp_r[b] = w;
          send(w, gaps);
          if ((sel >> (b + 1)) == '0)
            chk(load_done === 1'b1, "R6 done after last word", {31'd0, load_done}, 32'd1);
          else
            chk(load_done === 1'b0, "R6 no done mid command", {31'd0, load_done}, 32'd0);
        end
      end
    end
    @(negedge clk);
    chk(load_done === 1'b0, "R6 done lasts one cycle", {31'd0, load_done}, 32'd0);
    cmp_all("R2 R3 R4 R9 bank contents");
  endtask

  initial begin
    #(4 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_data  = '0;
    for (int k = 0; k < 32; k++) exp_r[k] = '0;
    repeat (3) @(negedge clk);
    chk(in_ready === 1'b0, "R8 ready low in reset", {31'd0, in_ready}, 32'd0);
    chk(load_done === 1'b0, "R8 done low in reset", {31'd0, load_done}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready === 1'b1, "R7 ready after reset", {31'd0, in_ready}, 32'd1);
    cmp_all("R8 bank zero after reset");

    // R3: control word (bit 3) and fill value (bit 14)
    run_cmd(32'h0000_4008, 1'b0);
    chk(slot(3) === exp_r[3], "R3 control slot", slot(3), exp_r[3]);
    chk(slot(14) === exp_r[14], "R3 fill slot", slot(14), exp_r[14]);
    // R5: empty header
    run_cmd(32'h0000_0000, 1'b0);
    // R2: every defined register
    run_cmd(DEF, 1'b0);
    // R4: only undefined bits, must finish on the header
    run_cmd(32'h1FE2_A002, 1'b0);
    // R4: undefined and defined mixed, with gaps
    run_cmd(32'hFFFF_FFFE, 1'b1);
    // R1: clear only
    run_cmd(32'h0000_0001, 1'b0);
    chk(slot(12) === 32'd0, "R1 cleared slot", slot(12), 32'd0);
    // R1: clear then load one register
    run_cmd(DEF, 1'b1);
    run_cmd(32'h0000_0005, 1'b0);
    chk(slot(31) === 32'd0, "R1 clear before load", slot(31), 32'd0);

    for (int i = 0; i < 60; i++) begin
      logic [31:0] h;
      h = $urandom;
      if (i % 3 == 1) h = h & $urandom;
      if (i % 3 == 2) h = h & $urandom & $urandom;
      run_cmd(h, (i % 2) == 1);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule